// File: doc/BRIEF.md
# Single-Precision Register Format Converter

This block is purely combinational. It moves single-precision values between the 32-bit layout used in memory and the 64-bit layout used in the floating-point register file. In the register layout, a single-precision value carries an 11-bit exponent of the double-precision kind. The exponent is widened by a fixed bit rule, not by an adder:

- An all-zero exponent stays zero.
- An all-ones exponent becomes all ones.
- Every other value lands at the same real magnitude.

The reverse path picks the fields back out of a register word. This restores the memory word exactly for any register value produced by the forward path.

A third path takes a 64-bit integer held in a register and packs its low 32 bits into the split longword layout. In that layout the top two integer bits sit at register bits 63:62 and the remaining 30 bits sit at 58:29. This path raises a pair of flags when the integer does not fit in 32 signed bits.

A 2-bit mode input picks the path:

| Mode | Path |
|------|------|
| 0 | memory to register |
| 1 | register to memory |
| 2 | integer to longword |
| 3 | idle |

The block has no arithmetic, rounding or NaN handling.

Top module: `sp_regfmt_conv`

## Requirements
- R1: In mode 0, `conv_out[63]` is `mem_word[31]`, `conv_out[51:29]` is `mem_word[22:0]`, and `conv_out[28:0]` is zero.
- R2: In mode 0, the memory exponent E = `mem_word[30:23]` in the range 1..254 yields the register exponent `conv_out[62:52]` = E + 896.
- R3: In mode 0, a memory exponent of 255 yields the register exponent 0x7FF.
- R4: In mode 0, a memory exponent of 0 yields the register exponent 0, whatever the fraction.
- R5: In mode 1, `conv_out[31:30]` is `reg_word[63:62]`, `conv_out[29:0]` is `reg_word[58:29]`, and `conv_out[63:32]` is zero.
- R6: In mode 2, `conv_out[63:62]` is `reg_word[31:30]`, `conv_out[58:29]` is `reg_word[29:0]`, and all other output bits are zero.
- R7: In mode 2, `iov_flag` and `ine_flag` are both 1 exactly when `reg_word`, read as signed, lies outside -2^31..2^31-1. Otherwise both are 0.
- R8: Outside mode 2 both flags are 0. In mode 3 `conv_out` is zero.
- R9: Feeding the mode 0 output back in mode 1 returns the original memory word, for every exponent value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_sel | input | 2 | Path select: 0 memory to register, 1 register to memory, 2 integer to longword, 3 idle |
| mem_word | input | 32 | Single-precision memory image |
| reg_word | input | 64 | Register image, or 64-bit integer in mode 2 |
| conv_out | output | 64 | Converted word; in mode 1 the result is in the low 32 bits |
| iov_flag | output | 1 | Integer overflow flag (mode 2 only) |
| ine_flag | output | 1 | Inexact flag, raised together with `iov_flag` |

## Verification
The embedded assertions check the properties that follow from the mode alone, whenever the inputs change:
- the two flags always agree;
- the flags stay low outside the integer path;
- the idle mode gives zero;
- the zero bands of the forward and reverse layouts stay zero.

Exponent widening cannot be seen from the output shape, and neither can the exact field placement, the overflow boundaries at ±2^31 or the round trip. The bench shows these. It sweeps all 256 memory exponents with several signs and fractions and compares each result with the value computed arithmetically (E + 896). It then feeds every result back through the reverse path. Finally, it drives integers at and just beyond the 32-bit signed limits.

// File: rtl/sp_regfmt_conv.sv
module sp_regfmt_conv (
  input  logic [1:0]  mode_sel,
  input  logic [31:0] mem_word,
  input  logic [63:0] reg_word,
  output logic [63:0] conv_out,
  output logic        iov_flag,
  output logic        ine_flag
);

  localparam logic [1:0] MODE_M2R  = 2'd0;
  localparam logic [1:0] MODE_R2M  = 2'd1;
  localparam logic [1:0] MODE_I2L  = 2'd2;
  localparam logic [1:0] MODE_IDLE = 2'd3;

  logic        exp_top;
  logic [6:0]  exp_rest;
  logic [10:0] wide_exp;
  logic [63:0] fwd_word, rev_word, lw_word;
  logic        int_wide;

  assign exp_top  = mem_word[30];
  assign exp_rest = mem_word[29:23];

  always_comb begin
    wide_exp = {exp_top, 3'b000, exp_rest};
    if (exp_top && (&exp_rest))
      wide_exp = 11'h7FF;
    else if (!exp_top && (|exp_rest))
      wide_exp[9:7] = 3'b111;
  end

  assign fwd_word = {mem_word[31], wide_exp, mem_word[22:0], 29'd0};
  assign rev_word = {32'd0, reg_word[63:62], reg_word[58:29]};
  assign lw_word  = {reg_word[31:30], 3'b000, reg_word[29:0], 29'd0};
  assign int_wide = reg_word[63:32] != {32{reg_word[31]}};

  always_comb begin
    unique case (mode_sel)
      MODE_M2R: conv_out = fwd_word;
      MODE_R2M: conv_out = rev_word;
      MODE_I2L: conv_out = lw_word;
      default:  conv_out = 64'd0;
    endcase
  end

  assign iov_flag = (mode_sel == MODE_I2L) && int_wide;
  assign ine_flag = (mode_sel == MODE_I2L) && int_wide;

  always_comb begin
    p_flags_paired_r7: assert (iov_flag == ine_flag)
      else $error("R7 flag pair mismatch");
    p_flags_quiet_r8: assert (mode_sel == MODE_I2L || (!iov_flag && !ine_flag))
      else $error("R8 flag outside integer path");
    p_idle_zero_r8: assert (mode_sel != MODE_IDLE || conv_out == 64'd0)
      else $error("R8 idle output nonzero");
    p_fwd_low_zero_r1: assert (mode_sel != MODE_M2R || conv_out[28:0] == 29'd0)
      else $error("R1 low band nonzero");
    p_rev_high_zero_r5: assert (mode_sel != MODE_R2M || conv_out[63:32] == 32'd0)
      else $error("R5 upper half nonzero");
    p_lw_gap_zero_r6: assert (mode_sel != MODE_I2L || (conv_out[61:59] == 3'd0 && conv_out[28:0] == 29'd0))
      else $error("R6 gap bits nonzero");
  end

endmodule

// File: tb/sp_regfmt_conv_tb.sv
module sp_regfmt_conv_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]  mode_sel;
  logic [31:0] mem_word;
  logic [63:0] reg_word;
  logic [63:0] conv_out;
  logic        iov_flag, ine_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  sp_regfmt_conv dut_i (
    .mode_sel(mode_sel), .mem_word(mem_word), .reg_word(reg_word),
    .conv_out(conv_out), .iov_flag(iov_flag), .ine_flag(ine_flag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [31:0] mw, input logic [63:0] rw);
    @(posedge clk);
    mode_sel = m; mem_word = mw; reg_word = rw;
    @(negedge clk);
  endtask

  task automatic int_case(input logic [63:0] v);
    logic ovf;
    logic [63:0] exp_w;
    ovf = ($signed(v) > 64'sh7FFF_FFFF) || ($signed(v) < -64'sh8000_0000);
    exp_w = ((v & 64'hC000_0000) << 32) | ((v & 64'h3FFF_FFFF) << 29);
    apply(2'd2, 32'h0, v);
    check("R6 longword packing", conv_out, exp_w);
    check("R7 iov", {63'd0, iov_flag}, {63'd0, ovf});
    check("R7 ine", {63'd0, ine_flag}, {63'd0, ovf});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    mode_sel = 2'd3; mem_word = 32'hFFFF_FFFF; reg_word = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    check("R8 idle output zero", conv_out, 64'd0);
    check("R8 idle flags", {62'd0, iov_flag, ine_flag}, 64'd0);

    for (int e = 0; e < 256; e++) begin
      for (int v = 0; v < 4; v++) begin
        logic [22:0] frac;
        logic        sgn;
        logic [10:0] exp_e;
        logic [31:0] mw;
        logic [63:0] fwd;
        frac = (v == 0) ? 23'd0 : (v == 1) ? 23'h7FFFFF : (v == 2) ? 23'h000001 : lfsr[22:0];
        sgn  = v[0] ^ e[0];
        mw   = {sgn, e[7:0], frac};
        if (e == 0)        exp_e = 11'd0;
        else if (e == 255) exp_e = 11'h7FF;
        else               exp_e = 11'(e + 896);
        apply(2'd0, mw, 64'h0);
        fwd = conv_out;
        check("R1 sign", {63'd0, conv_out[63]}, {63'd0, sgn});
        check("R1 fraction and low band", {35'd0, conv_out[51:0]}, {35'd0, frac, 29'd0});
        if (e == 0)        check("R4 zero exponent", {53'd0, conv_out[62:52]}, {53'd0, exp_e});
        else if (e == 255) check("R3 top exponent", {53'd0, conv_out[62:52]}, {53'd0, exp_e});
        else               check("R2 rebiased exponent", {53'd0, conv_out[62:52]}, {53'd0, exp_e});
        check("R8 no flags in mode 0", {62'd0, iov_flag, ine_flag}, 64'd0);
        apply(2'd1, 32'h0, fwd);
        check("R9 round trip", conv_out, {32'd0, mw});
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      end
    end

    for (int k = 0; k < 200; k++) begin
      logic [63:0] rw;
      logic [63:0] exp_w;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rw = {lfsr, ~lfsr ^ 32'h5A5A_5A5A};
      exp_w = ((rw >> 32) & 64'hC000_0000) | ((rw >> 29) & 64'h3FFF_FFFF);
      apply(2'd1, 32'h0, rw);
      check("R5 field extraction", conv_out, exp_w);
      check("R8 no flags in mode 1", {62'd0, iov_flag, ine_flag}, 64'd0);
    end

    int_case(64'h0000_0000_7FFF_FFFF);
    int_case(64'h0000_0000_8000_0000);
    int_case(64'hFFFF_FFFF_8000_0000);
    int_case(64'hFFFF_FFFF_7FFF_FFFF);
    int_case(64'h0);
    int_case(64'hFFFF_FFFF_FFFF_FFFF);
    int_case(64'h8000_0000_0000_0000);
    int_case(64'h0000_0001_0000_0000);
    for (int k = 0; k < 100; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      int_case({{32{lfsr[31]}}, lfsr});
      int_case({lfsr ^ 32'h0F0F_0F0F, lfsr});
    end

    apply(2'd3, 32'h4049_0FDB, 64'h1234_5678_9ABC_DEF0);
    check("R8 idle output zero", conv_out, 64'd0);
    check("R8 idle flags", {62'd0, iov_flag, ine_flag}, 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule